// File: doc/BRIEF.md
# Indirect Register Read Port

This block is the host-side path for reading per-channel internal registers through indirection. The host writes a 16-bit indirect address to one direct address. It then reads the selected 32-bit value as two 16-bit words at two other direct addresses. The top nibble of the indirect address picks a channel (0 to NCH-1) or the global nibble F. The low twelve bits pick the location inside that channel.

Some locations are frequency words that the datapath keeps updating: the carrier frequency at offset 0x006 and the upper 32 bits of the timing frequency at offset 0x009. Writing their indirect address raises a fetch strobe. That strobe copies the value into a holding register, so the two data words always come from one sample. The input level detector at global address 0xF806 is read live.

The AGC gain of every channel is sampled in one cycle by an indirect write to offset 0x00F. Reads at offset 0x00F return that captured gain. A read through a channel nibble outside 0..NCH-1 and F returns zero and sets a sticky error flag.

Top module: `ira_read_port`

## Requirements
- R1: After synchronous reset, host_rdata is 0 and rd_err is 0. Captured gains and the snapshot register are also 0.
- R2: Direct address map.
  - A write at direct address 3 loads the indirect read address.
  - A read at direct address 0 returns bits 15:0 of the selected 32-bit value, and a read at direct address 1 returns bits 31:16.
  - A write at direct address 4 is an indirect write.
  - Reads at any other direct address return 0.
- R3: Indirect address bits 15:12 select the channel, and bits 11:0 select the offset. Offset 0x006 of a channel selects its carrier frequency word, and offset 0x009 selects its timing frequency word.
- R4: Writing a carrier or timing address snapshots the value once. Later changes of the source do not appear in reads until the indirect address is written again.
- R5: The snapshot is loaded on the clock edge after the edge that accepts the indirect address write. A data read registered on that later edge returns the previous snapshot.
- R6: Address 0xF806 returns the level detector input live. A change shows on the next read without any new address write.
- R7: An indirect write (direct address 4) whose offset is 0x00F and whose nibble is valid captures every channel's AGC gain on the accepting edge. Any other indirect write captures nothing.
- R8: Reads at offset 0x00F of channel c return the captured gain of c in the low word and 0 in the high word.
- R9: Suppose a data read (address 0 or 1) occurs while the channel nibble is neither below NCH nor F. That read returns 0 and sets rd_err. rd_err stays 1 until reset.
- R10: A valid nibble with an unmapped offset returns 0 without setting rd_err. This includes nibble F with any offset other than 0x806, and channel nibbles with 0x806.
- R11: host_rdata is registered and changes only on a clock edge where host_rd is high.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write enable |
| host_rd | input | 1 | Host read enable |
| host_addr | input | 3 | Direct address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| rd_err | output | 1 | Sticky invalid-channel read flag |
| carrier_freq | input | NCH×32 | Per-channel active carrier frequency words |
| timing_freq | input | NCH×32 | Per-channel timing frequency upper words |
| agc_gain | input | NCH×16 | Per-channel live AGC gain |
| level_det | input | 32 | Input level detector output |

## Verification
The bench reads in the cycle right after a fetch to confirm that the previous snapshot comes back. A design that loads the snapshot on the write edge would return the new value there instead. The bench changes sources after a fetch and after a gain capture. A design that passes live values through would leak those changes, while one that snapshots the level detector would hide them. The bench probes invalid nibbles, the global nibble with a wrong offset, and non-gain indirect writes. These expose a missing or over-eager error flag and stray gain captures.

// File: rtl/ira_pkg.sv
package ira_pkg;
  localparam logic [2:0]  ADDR_LO     = 3'd0;
  localparam logic [2:0]  ADDR_HI     = 3'd1;
  localparam logic [2:0]  ADDR_IRA    = 3'd3;
  localparam logic [2:0]  ADDR_IWA    = 3'd4;
  localparam logic [11:0] OFF_CARRIER = 12'h006;
  localparam logic [11:0] OFF_TIMING  = 12'h009;
  localparam logic [11:0] OFF_GAIN    = 12'h00F;
  localparam logic [11:0] OFF_LEVEL   = 12'h806;
  localparam logic [3:0]  NIB_GLOBAL  = 4'hF;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_CARRIER,
    SRC_TIMING,
    SRC_GAIN,
    SRC_LEVEL
  } src_e;
endpackage

// File: rtl/ira_decode.sv
module ira_decode
  import ira_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic [15:0]   ind_addr,
  output src_e          src,
  output logic [CW-1:0] chan,
  output logic          nib_ok,
  output logic          gain_wr_ok
);
  logic [3:0]  nib;
  logic [11:0] off;
  logic        is_chan;

  assign nib        = ind_addr[15:12];
  assign off        = ind_addr[11:0];
  assign is_chan    = int'(nib) < NCH;
  assign nib_ok     = is_chan || (nib == NIB_GLOBAL);
  assign chan       = nib[CW-1:0];
  assign gain_wr_ok = nib_ok && (off == OFF_GAIN);

  always_comb begin
    src = SRC_NONE;
    if (nib == NIB_GLOBAL) begin
      if (off == OFF_LEVEL) src = SRC_LEVEL;
    end else if (is_chan) begin
      case (off)
        OFF_CARRIER: src = SRC_CARRIER;
        OFF_TIMING:  src = SRC_TIMING;
        OFF_GAIN:    src = SRC_GAIN;
        default:     src = SRC_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ira_snapshot.sv
module ira_snapshot #(
  parameter int NCH = 4,
  parameter int FW  = 32,
  localparam int CW = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fetch,
  input  logic                    use_timing,
  input  logic [CW-1:0]           chan,
  input  logic [NCH-1:0][FW-1:0]  carrier,
  input  logic [NCH-1:0][FW-1:0]  timing,
  output logic [FW-1:0]           snap
);
  logic [FW-1:0] picked;

  assign picked = use_timing ? timing[chan] : carrier[chan];

  always_ff @(posedge clk) begin
    if (rst)        snap <= '0;
    else if (fetch) snap <= picked;
  end

  // R5
  snap_load_chk: assert property (@(posedge clk) disable iff (rst)
    fetch |=> snap == $past(picked));
  // R4
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch |=> $stable(snap));
endmodule

// File: rtl/ira_gain_bank.sv
module ira_gain_bank #(
  parameter int NCH = 4,
  parameter int GW  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   capture,
  input  logic [NCH-1:0][GW-1:0] gain_in,
  output logic [NCH-1:0][GW-1:0] gain_q
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)          gain_q[g] <= '0;
      else if (capture) gain_q[g] <= gain_in[g];
    end
  end

  // R7
  gain_cap_chk: assert property (@(posedge clk) disable iff (rst)
    capture |=> gain_q == $past(gain_in));
  // R7
  gain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(gain_q));
endmodule

// File: rtl/ira_read_port.sv
module ira_read_port
  import ira_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int FW  = 32,
  parameter int GW  = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   host_wr,
  input  logic                   host_rd,
  input  logic [2:0]             host_addr,
  input  logic [DW-1:0]          host_wdata,
  output logic [DW-1:0]          host_rdata,
  output logic                   rd_err,
  input  logic [NCH-1:0][FW-1:0] carrier_freq,
  input  logic [NCH-1:0][FW-1:0] timing_freq,
  input  logic [NCH-1:0][GW-1:0] agc_gain,
  input  logic [FW-1:0]          level_det
);
  logic [15:0]   ind_addr_q;
  logic          fetch_q;
  src_e          rd_src, wr_src;
  logic [CW-1:0] rd_chan, wr_chan;
  logic          rd_nib_ok, wr_nib_ok, rd_gain_ok, wr_gain_ok;
  logic [FW-1:0] snap;
  logic [NCH-1:0][GW-1:0] gain_q;
  logic [FW-1:0] word;
  logic          ira_wr, iwa_wr, data_rd;

  assign ira_wr  = host_wr && host_addr == ADDR_IRA;
  assign iwa_wr  = host_wr && host_addr == ADDR_IWA;
  assign data_rd = host_rd && (host_addr == ADDR_LO || host_addr == ADDR_HI);

  ira_decode #(.NCH(NCH)) u_rd_dec (
    .ind_addr(ind_addr_q), .src(rd_src), .chan(rd_chan),
    .nib_ok(rd_nib_ok), .gain_wr_ok(rd_gain_ok));

  ira_decode #(.NCH(NCH)) u_wr_dec (
    .ind_addr(host_wdata[15:0]), .src(wr_src), .chan(wr_chan),
    .nib_ok(wr_nib_ok), .gain_wr_ok(wr_gain_ok));

  always_ff @(posedge clk) begin
    if (rst) begin
      ind_addr_q <= '0;
      fetch_q    <= 1'b0;
    end else begin
      fetch_q <= ira_wr && (wr_src == SRC_CARRIER || wr_src == SRC_TIMING);
      if (ira_wr) ind_addr_q <= host_wdata[15:0];
    end
  end

  ira_snapshot #(.NCH(NCH), .FW(FW)) u_snap (
    .clk(clk), .rst(rst), .fetch(fetch_q),
    .use_timing(rd_src == SRC_TIMING), .chan(rd_chan),
    .carrier(carrier_freq), .timing(timing_freq), .snap(snap));

  ira_gain_bank #(.NCH(NCH), .GW(GW)) u_gain (
    .clk(clk), .rst(rst), .capture(iwa_wr && wr_gain_ok),
    .gain_in(agc_gain), .gain_q(gain_q));

  always_comb begin
    word = '0;
    case (rd_src)
      SRC_CARRIER, SRC_TIMING: word = snap;
      SRC_GAIN:                word = FW'(gain_q[rd_chan]);
      SRC_LEVEL:               word = level_det;
      default:                 word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      rd_err     <= 1'b0;
    end else if (host_rd) begin
      case (host_addr)
        ADDR_LO: host_rdata <= word[DW-1:0];
        ADDR_HI: host_rdata <= word[2*DW-1:DW];
        default: host_rdata <= '0;
      endcase
      if (data_rd && !rd_nib_ok) rd_err <= 1'b1;
    end
  end

  // R1
  init_chk: assert property (@(posedge clk) rst |=> host_rdata == '0 && !rd_err);
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rd_err |=> rd_err);
  // R9
  bad_nib_chk: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !rd_nib_ok) |=> host_rdata == '0 && rd_err);
  // R5
  fetch_after_ira_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_q |-> $past(ira_wr));
endmodule

// File: tb/ira_read_port_bench.sv
module ira_read_port_bench;
  localparam int NCH = 4;
  logic clk = 0, rst = 1, host_wr = 0, host_rd = 0;
  logic [2:0]  host_addr = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic        rd_err;
  logic [NCH-1:0][31:0] carrier_freq = '0, timing_freq = '0;
  logic [NCH-1:0][15:0] agc_gain = '0;
  logic [31:0] level_det = '0;
  int errs = 0, checks = 0;
  logic [15:0] rv;

  always #4 clk = ~clk;

  ira_read_port #(.NCH(NCH)) u_ira_read_port (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    host_rd = 1; host_addr = a;
    @(negedge clk);
    host_rd = 0; d = host_rdata;
  endtask

  task automatic idle(); @(negedge clk); endtask

  task automatic t_reset();
    check("R1 rdata", host_rdata, 0);
    check("R1 err", rd_err, 0);
    wr(3, 16'h000F); rd(0, rv);
    check("R1 gain clear", rv, 0);
  endtask

  task automatic t_carrier();
    carrier_freq[2] = 32'hA1B2C3D4;
    wr(3, 16'h2006); idle();
    rd(0, rv); check("R3 carrier lo", rv, 16'hC3D4);
    rd(1, rv); check("R2 carrier hi", rv, 16'hA1B2);
    rd(2, rv); check("R2 unmapped direct", rv, 0);
    carrier_freq[2] = 32'h11112222;
    idle();
    rd(0, rv); check("R4 stale lo", rv, 16'hC3D4);
    wr(3, 16'h2006); idle();
    rd(0, rv); check("R4 refetched lo", rv, 16'h2222);
  endtask

  task automatic t_fetch_cycle();
    timing_freq[1] = 32'h5A5A7E7E;
    wr(3, 16'h1009);
    rd(0, rv); check("R5 previous snapshot", rv, 16'h2222);
    rd(1, rv); check("R5 new timing hi", rv, 16'h5A5A);
  endtask

  task automatic t_level();
    level_det = 32'h0000BEEF;
    wr(3, 16'hF806); idle();
    rd(0, rv); check("R6 level lo", rv, 16'hBEEF);
    level_det = 32'h12340042;
    rd(0, rv); check("R6 live lo", rv, 16'h0042);
    rd(1, rv); check("R6 live hi", rv, 16'h1234);
  endtask

  task automatic t_gain();
    for (int c = 0; c < NCH; c++) agc_gain[c] = 16'h1000 + 16'(c * 16'h0111);
    wr(4, 16'h0006);
    wr(3, 16'h300F); idle();
    rd(0, rv); check("R7 no capture on other offset", rv, 0);
    wr(4, 16'h200F);
    for (int c = 0; c < NCH; c++) agc_gain[c] = 16'hFFFF;
    for (int c = 0; c < NCH; c++) begin
      wr(3, 16'(c << 12) | 16'h000F); idle();
      rd(0, rv); check("R8 gain lo", rv, 16'h1000 + 16'(c * 16'h0111));
      rd(1, rv); check("R8 gain hi", rv, 0);
    end
  endtask

  task automatic t_unmapped();
    wr(3, 16'hF006); idle();
    rd(0, rv); check("R10 global bad offset", rv, 0);
    wr(3, 16'h1806); idle();
    rd(0, rv); check("R10 chan level offset", rv, 0);
    check("R10 no err", rd_err, 0);
  endtask

  task automatic t_invalid();
    carrier_freq[1] = 32'hCAFE0123;
    wr(3, 16'h5006); idle();
    check("R9 err before read", rd_err, 0);
    rd(0, rv); check("R9 invalid data", rv, 0);
    check("R9 err set", rd_err, 1);
    wr(3, 16'h1006); idle();
    rd(0, rv); check("R9 valid after", rv, 16'h0123);
    check("R9 sticky", rd_err, 1);
  endtask

  task automatic t_hold();
    idle(); idle();
    check("R11 hold", host_rdata, 16'h0123);
    wr(3, 16'h0006); idle();
    check("R11 hold after write", host_rdata, 16'h0123);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset(); t_carrier(); t_fetch_cycle(); t_level();
        t_gain(); t_unmapped(); t_invalid(); t_hold();
      end
      begin
        repeat (5000) @(negedge clk);
        errs++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule